// File: doc/BRIEF.md
# Genlocked Top-of-Frame Pulse Generator

This block produces a one-clock top-of-frame (TOF) strobe from a free-running pixel counter and line counter. The pixel counter wraps at a programmed pixels-per-line count, and each wrap advances the line counter, which wraps at a programmed lines-per-frame count. The strobe fires on the cycle in which both counters read zero. The output pin also carries an output-enable, so a pad outside the block can tri-state it.

Software can lock the counters to an external reference frame, which is marked by horizontal and vertical sync pulses that are already synchronous to the clock. A rising edge on the init control, taken while alignment is enabled and the format is valid, arms the block. At the next reference frame start the counters are loaded so that the strobe trails the reference frame by a programmed number of lines. The load repeats at every later frame start for as long as the enable stays set. When the reference is invalid, the counters run freely on their terminal counts.

Two alarm flags are decoded from the genlock status inputs. One reports a missing reference and the other reports a lost lock. The block has no streaming data path, so all of its pins are plain control and status levels with no valid/ready handshake and no back-pressure.

Top module: `tof_genlock`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `tof_o` is 0.
- R2: With no alignment, `tof_o` is high for exactly one cycle out of every `cfg_ppl`×`cfg_lpf` cycles. The pixel count wraps to 0 after `cfg_ppl`−1.
- R3: A terminal count of 0 on `cfg_ppl` or `cfg_lpf` acts as a count of 1. With both at 0, `tof_o` is high on every cycle.
- R4: A reference frame start occurs only on a clock where `ref_hs` and `ref_vs` both rise, each compared with its value on the previous clock. A rise on only one of them causes no alignment.
- R5: A 0-to-1 change of `cfg_init` arms alignment only while `cfg_align_en` is 1. Holding `cfg_init` at 1 does not arm.
- R6: At the first frame start after arming, the counters are loaded. `tof_o` then goes high `cfg_line_ofs`×`cfg_ppl` cycles after the cycle that follows the frame-start clock, or on that following cycle itself when the offset is 0.
- R7: While `cfg_align_en` stays 1, every later frame start realigns the counters. Clearing `cfg_align_en` disarms the block, and later frame starts are then ignored until a new init edge arrives.
- R8: Alignment takes place only when `st_ref_valid` is 1. Without a valid reference the counters keep free-running.
- R9: A `cfg_line_ofs` value equal to or greater than the effective lines per frame acts as an offset of 0.
- R10: An init edge is ignored while `cfg_ppl` or `cfg_lpf` is 0, because the format is not valid.
- R11: `tof_oe` equals the inverse of `cfg_hiz`. The counters and the `tof_o` timing are unaffected by `cfg_hiz`.
- R12: `alarm_no_ref` equals NOT `st_ref_valid`. `alarm_no_lock` is 1 unless `st_ref_valid`, `st_lock_a` and `st_lock_b` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_hs | input | 1 | Reference horizontal sync (synchronous) |
| ref_vs | input | 1 | Reference vertical sync (synchronous) |
| cfg_ppl | input | PIX_W | Pixels per line (terminal count) |
| cfg_lpf | input | LINE_W | Lines per frame (terminal count) |
| cfg_line_ofs | input | LINE_W | Line delay of TOF behind reference frame |
| cfg_align_en | input | 1 | Alignment mode enable |
| cfg_init | input | 1 | Arm request, rising-edge sensitive |
| cfg_hiz | input | 1 | Tri-state request for the TOF pin |
| st_ref_valid | input | 1 | Reference present |
| st_lock_a | input | 1 | First lock status |
| st_lock_b | input | 1 | Second lock status |
| tof_o | output | 1 | Top-of-frame strobe |
| tof_oe | output | 1 | Output enable for the TOF pad |
| alarm_no_ref | output | 1 | Missing-reference alarm |
| alarm_no_lock | output | 1 | Lost-lock alarm |

## Verification
Several properties are checked on every cycle: the pixel-wrap and single-cycle strobe shape, the load values that follow an alignment, the degenerate terminal count, the rule that a frame start needs coincident sync levels, and the arming and disarming of the control state together with its need for a valid reference. The bench scenarios are needed for the end-to-end behaviour. These include the measured delay from a frame start to the strobe for a given offset, the point that a held init level or a lone H or V edge leaves the phase untouched, the out-of-range offset, the rejection of an invalid format, and the strobe timing that continues unchanged under tri-state. A random phase compares `tof_o` on every cycle against a bench model built from the requirements.

// File: rtl/tof_pkg.sv
package tof_pkg;
  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_SET  = 1'b1
  } arm_state_t;

  localparam int unsigned EDGE_INIT = 0;
  localparam int unsigned EDGE_VS   = 1;
  localparam int unsigned EDGE_HS   = 2;
  localparam int unsigned EDGE_NUM  = 3;
endpackage

// File: rtl/tof_edge_det.sv
module tof_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] sig_q;

  // Previous values reset to 1 so a level held through reset is not an edge.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q[g] <= 1'b1;
      else        sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
  end
endmodule

// File: rtl/tof_align_ctrl.sv
module tof_align_ctrl
  import tof_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_rise_i,
  input  logic frame_start_i,
  input  logic align_en_i,
  input  logic ref_valid_i,
  input  logic fmt_ok_i,
  output logic align_load_o
);
  arm_state_t arm_q, arm_d;

  // Once armed, the state holds while enable stays set: the block realigns
  // at every reference frame start until enable drops.
  always_comb begin
    arm_d = arm_q;
    if (!align_en_i)                   arm_d = ARM_IDLE;
    else if (init_rise_i && fmt_ok_i)  arm_d = ARM_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= ARM_IDLE;
    else        arm_q <= arm_d;
  end

  assign align_load_o = frame_start_i && (arm_q == ARM_SET) && align_en_i && ref_valid_i;

  // R7: dropping the enable disarms on the next cycle
  p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !align_en_i |=> (arm_q == ARM_IDLE));
  // R5: an honoured init edge arms
  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (align_en_i && init_rise_i && fmt_ok_i) |=> (arm_q == ARM_SET));
  // R10: invalid format never arms from idle
  p_fmt_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == ARM_IDLE && !fmt_ok_i) |=> (arm_q == ARM_IDLE));
endmodule

// File: rtl/tof_frame_cnt.sv
module tof_frame_cnt #(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  ppl_i,
  input  logic [LINE_W-1:0] lpf_i,
  input  logic [LINE_W-1:0] ofs_i,
  input  logic              align_load_i,
  output logic              tof_o
);
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic [PIX_W-1:0]  pix_q, pix_d, ppl_eff;
  logic [LINE_W-1:0] line_q, line_d, lpf_eff, ofs_eff, load_line;
  logic              pix_wrap, line_wrap, tof_q;

  assign ppl_eff   = (ppl_i == '0) ? PIX_ONE : ppl_i;
  assign lpf_eff   = (lpf_i == '0) ? LINE_ONE : lpf_i;
  assign ofs_eff   = (ofs_i >= lpf_eff) ? '0 : ofs_i;
  assign load_line = (ofs_eff == '0) ? '0 : (lpf_eff - ofs_eff);
  assign pix_wrap  = (pix_q >= ppl_eff - PIX_ONE);
  assign line_wrap = (line_q >= lpf_eff - LINE_ONE);

  always_comb begin
    pix_d  = pix_q + PIX_ONE;
    line_d = line_q;
    if (align_load_i) begin
      pix_d  = '0;
      line_d = load_line;
    end else if (pix_wrap) begin
      pix_d  = '0;
      line_d = line_wrap ? '0 : (line_q + LINE_ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      tof_q  <= 1'b0;
    end else begin
      pix_q  <= pix_d;
      line_q <= line_d;
      tof_q  <= (pix_d == '0) && (line_d == '0);
    end
  end

  assign tof_o = tof_q;

  // R2: pixel counter returns to zero after its terminal count
  p_pix_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_wrap && !align_load_i) |=> (pix_q == '0));
  // R2: strobe lasts one cycle when a line holds more than one pixel
  p_tof_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tof_q && ppl_i > PIX_ONE && !align_load_i) |=> !tof_q);
  // R3: zero pixel count behaves as one
  p_zero_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ppl_i == '0 && !align_load_i) |=> (pix_q == '0));
  // R6: alignment loads pixel zero and the offset line
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    align_load_i |=> (pix_q == '0 && line_q == $past(load_line)));
endmodule

// File: rtl/tof_genlock.sv
module tof_genlock
  import tof_pkg::*;
#(
  parameter int unsigned PIX_W  = 12,
  parameter int unsigned LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_hs,
  input  logic              ref_vs,
  input  logic [PIX_W-1:0]  cfg_ppl,
  input  logic [LINE_W-1:0] cfg_lpf,
  input  logic [LINE_W-1:0] cfg_line_ofs,
  input  logic              cfg_align_en,
  input  logic              cfg_init,
  input  logic              cfg_hiz,
  input  logic              st_ref_valid,
  input  logic              st_lock_a,
  input  logic              st_lock_b,
  output logic              tof_o,
  output logic              tof_oe,
  output logic              alarm_no_ref,
  output logic              alarm_no_lock
);
  logic [EDGE_NUM-1:0] edge_in, edge_rise;
  logic frame_start, fmt_ok, align_load;

  always_comb begin
    edge_in            = '0;
    edge_in[EDGE_INIT] = cfg_init;
    edge_in[EDGE_VS]   = ref_vs;
    edge_in[EDGE_HS]   = ref_hs;
  end

  tof_edge_det #(.N(EDGE_NUM)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (edge_in),
    .rise_o (edge_rise)
  );

  assign frame_start = edge_rise[EDGE_VS] & edge_rise[EDGE_HS];
  assign fmt_ok      = (cfg_ppl != '0) && (cfg_lpf != '0);

  tof_align_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_rise_i   (edge_rise[EDGE_INIT]),
    .frame_start_i (frame_start),
    .align_en_i    (cfg_align_en),
    .ref_valid_i   (st_ref_valid),
    .fmt_ok_i      (fmt_ok),
    .align_load_o  (align_load)
  );

  tof_frame_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .ppl_i        (cfg_ppl),
    .lpf_i        (cfg_lpf),
    .ofs_i        (cfg_line_ofs),
    .align_load_i (align_load),
    .tof_o        (tof_o)
  );

  assign tof_oe        = ~cfg_hiz;
  assign alarm_no_ref  = ~st_ref_valid;
  assign alarm_no_lock = ~(st_ref_valid & st_lock_a & st_lock_b);

  // R4: a frame start needs both sync inputs high
  p_frame_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (ref_hs && ref_vs));
  // R8: no alignment without a valid reference
  p_align_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    align_load |-> st_ref_valid);
endmodule

// File: tb/test_tof_genlock.sv
module test_tof_genlock;
  localparam int PW = 12;
  localparam int LW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_hs = 1'b0, ref_vs = 1'b0;
  logic [PW-1:0] cfg_ppl = PW'(4);
  logic [LW-1:0] cfg_lpf = LW'(3);
  logic [LW-1:0] cfg_line_ofs = '0;
  logic cfg_align_en = 1'b0, cfg_init = 1'b0, cfg_hiz = 1'b0;
  logic st_ref_valid = 1'b1, st_lock_a = 1'b1, st_lock_b = 1'b1;
  logic tof_o, tof_oe, alarm_no_ref, alarm_no_lock;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tof_genlock #(.PIX_W(PW), .LINE_W(LW)) i_tof_genlock (
    .clk(clk), .rst_n(rst_n), .ref_hs(ref_hs), .ref_vs(ref_vs),
    .cfg_ppl(cfg_ppl), .cfg_lpf(cfg_lpf), .cfg_line_ofs(cfg_line_ofs),
    .cfg_align_en(cfg_align_en), .cfg_init(cfg_init), .cfg_hiz(cfg_hiz),
    .st_ref_valid(st_ref_valid), .st_lock_a(st_lock_a), .st_lock_b(st_lock_b),
    .tof_o(tof_o), .tof_oe(tof_oe), .alarm_no_ref(alarm_no_ref),
    .alarm_no_lock(alarm_no_lock)
  );

  // Requirement model
  int m_pix, m_line, t_pe, t_le, t_oe, t_ld, t_np, t_nl;
  bit m_arm, m_tof, m_hs_p, m_vs_p, m_init_p, t_fs, t_al;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix <= 0; m_line <= 0; m_arm <= 0; m_tof <= 0;
      m_hs_p <= 1; m_vs_p <= 1; m_init_p <= 1;
    end else begin
      t_pe = (cfg_ppl == 0) ? 1 : int'(cfg_ppl);
      t_le = (cfg_lpf == 0) ? 1 : int'(cfg_lpf);
      t_oe = (int'(cfg_line_ofs) >= t_le) ? 0 : int'(cfg_line_ofs);
      t_ld = (t_oe == 0) ? 0 : t_le - t_oe;
      t_fs = ref_hs && !m_hs_p && ref_vs && !m_vs_p;
      t_al = t_fs && m_arm && cfg_align_en && st_ref_valid;
      if (t_al) begin t_np = 0; t_nl = t_ld; end
      else if (m_pix >= t_pe - 1) begin
        t_np = 0; t_nl = (m_line >= t_le - 1) ? 0 : m_line + 1;
      end else begin t_np = m_pix + 1; t_nl = m_line; end
      m_pix <= t_np; m_line <= t_nl;
      m_tof <= (t_np == 0) && (t_nl == 0);
      if (!cfg_align_en) m_arm <= 0;
      else if (cfg_init && !m_init_p && cfg_ppl != 0 && cfg_lpf != 0) m_arm <= 1;
      m_hs_p <= ref_hs; m_vs_p <= ref_vs; m_init_p <= cfg_init;
    end
  end

  function automatic int exp_delay(int ofs, int ppl, int lpf);
    int le = (lpf == 0) ? 1 : lpf;
    int pe = (ppl == 0) ? 1 : ppl;
    int oe = (ofs >= le) ? 0 : ofs;
    return oe * pe;
  endfunction

  function automatic bit exp_no_lock(bit v, bit a, bit b);
    return !(v && a && b);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare tof_o with the model for n cycles, one check
  task automatic run_chk(int n, string tag);
    int bad = 0; int a = 0; int e = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tof_o !== m_tof) begin
        if (bad == 0) begin a = int'(tof_o); e = int'(m_tof); end
        bad++;
      end
    end
    chk(bad == 0, tag, a, e);
  endtask

  task automatic arm();
    cfg_align_en = 1'b1; cfg_init = 1'b0;
    @(negedge clk); cfg_init = 1'b1;
    @(negedge clk); cfg_init = 1'b0;
    @(negedge clk);
  endtask

  // Coincident frame start; returns at the negedge after the sampling edge
  task automatic frame_pulse(bit h, bit v);
    ref_hs = h; ref_vs = v;
    @(negedge clk); ref_hs = 1'b0; ref_vs = 1'b0;
  endtask

  task automatic measure(int limit, output int idx);
    idx = -1;
    for (int i = 0; i < limit; i++) begin
      if (tof_o === 1'b1) begin idx = i; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int idx, p;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    chk(tof_o === 1'b0, "R1 in reset", int'(tof_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tof_o === 1'b0, "R1 after release", int'(tof_o), 0);

    // R2 free run
    run_chk(40, "R2 free run 4x3");
    measure(30, idx);
    @(negedge clk);
    p = 1;
    while (tof_o !== 1'b1 && p < 40) begin @(negedge clk); p++; end
    chk(p == 12, "R2 period", p, 12);

    // R3 zero terminal counts
    cfg_ppl = '0; cfg_lpf = '0;
    repeat (2) @(negedge clk);
    idx = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (tof_o === 1'b1) idx++; end
    chk(idx == 5, "R3 every cycle", idx, 5);

    // R10 invalid format ignores init edge
    cfg_ppl = PW'(7); cfg_lpf = '0;
    arm();
    cfg_lpf = LW'(5);
    frame_pulse(1, 1);
    run_chk(40, "R10 no arm on bad format");

    // R12 alarms
    for (int k = 0; k < 8; k++) begin
      st_ref_valid = k[0]; st_lock_a = k[1]; st_lock_b = k[2];
      #1;
      chk(alarm_no_ref === !k[0], "R12 no_ref", int'(alarm_no_ref), int'(!k[0]));
      chk(alarm_no_lock === exp_no_lock(k[0], k[1], k[2]), "R12 no_lock",
          int'(alarm_no_lock), int'(exp_no_lock(k[0], k[1], k[2])));
    end
    st_ref_valid = 1; st_lock_a = 1; st_lock_b = 1;
    @(negedge clk);

    // R6 offset 0
    cfg_ppl = PW'(7); cfg_lpf = LW'(5); cfg_line_ofs = '0;
    arm();
    frame_pulse(1, 1);
    measure(60, idx);
    chk(idx == exp_delay(0, 7, 5), "R6 offset 0", idx, exp_delay(0, 7, 5));

    // R4 lone edges do nothing; R7 repeat alignment while enabled
    run_chk(10, "R4 pre");
    frame_pulse(1, 0); run_chk(6, "R4 lone H");
    frame_pulse(0, 1); run_chk(6, "R4 lone V");
    cfg_line_ofs = LW'(2);
    frame_pulse(1, 1);
    measure(60, idx);
    chk(idx == exp_delay(2, 7, 5), "R7 realign offset 2", idx, exp_delay(2, 7, 5));
    run_chk(20, "R6 model after realign");

    // R7 enable cleared: no realign
    cfg_align_en = 1'b0; @(negedge clk); @(negedge clk);
    frame_pulse(1, 1);
    run_chk(40, "R7 disabled ignores frame");

    // R5 held init level does not arm
    cfg_init = 1'b1; @(negedge clk);
    cfg_align_en = 1'b1; @(negedge clk);
    frame_pulse(1, 1);
    run_chk(40, "R5 level no arm");
    cfg_init = 1'b0;

    // R8 invalid reference
    arm();
    st_ref_valid = 1'b0;
    frame_pulse(1, 1);
    run_chk(40, "R8 no ref free run");
    st_ref_valid = 1'b1;

    // R9 offset out of range
    cfg_ppl = PW'(5); cfg_lpf = LW'(4); cfg_line_ofs = LW'(9);
    @(negedge clk);
    frame_pulse(1, 1);
    measure(40, idx);
    chk(idx == 0, "R9 large offset", idx, 0);

    // R6 offset 3 with another format
    cfg_ppl = PW'(6); cfg_lpf = LW'(8); cfg_line_ofs = LW'(3);
    @(negedge clk);
    frame_pulse(1, 1);
    measure(80, idx);
    chk(idx == exp_delay(3, 6, 8), "R6 offset 3", idx, exp_delay(3, 6, 8));

    // R11 hi-z
    cfg_hiz = 1'b1; #1;
    chk(tof_oe === 1'b0, "R11 oe off", int'(tof_oe), 0);
    run_chk(60, "R11 timing under hiz");
    cfg_hiz = 1'b0; #1;
    chk(tof_oe === 1'b1, "R11 oe on", int'(tof_oe), 1);

    // Random phase
    for (int blk = 0; blk < 20; blk++) begin
      cfg_ppl = PW'($urandom_range(0, 9));
      cfg_lpf = LW'($urandom_range(0, 6));
      cfg_line_ofs = LW'($urandom_range(0, 7));
      begin
        int bad = 0; int a = 0; int e = 0;
        for (int c = 0; c < 300; c++) begin
          ref_hs = ($urandom_range(0, 9) == 0);
          ref_vs = ($urandom_range(0, 9) == 0);
          if ($urandom_range(0, 30) == 0) begin ref_hs = 1; ref_vs = 1; end
          if ($urandom_range(0, 20) == 0) cfg_init = ~cfg_init;
          if ($urandom_range(0, 80) == 0) cfg_align_en = ~cfg_align_en;
          if ($urandom_range(0, 60) == 0) st_ref_valid = ~st_ref_valid;
          cfg_hiz = ($urandom_range(0, 15) == 0);
          @(negedge clk);
          if (tof_o !== m_tof) begin
            if (bad == 0) begin a = int'(tof_o); e = int'(m_tof); end
            bad++;
          end
        end
        chk(bad == 0, "R2/R6 random block", a, e);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule